// File: doc/BRIEF.md
# Cache Hierarchy Level Enumerator

This block walks a 64-bit cache identification word one level per clock. A single-cycle start pulse captures the word and a tag-feature enable. The walk begins at level 1 and moves outward. At each level it reports the level number, the decoded cache kind and the tag-cache kind. The walk ends at the first level whose cache kind is "none", or after level seven. At the end it pulses done, reports how many levels were present, and says whether any reserved encoding was seen.

The three 3-bit hierarchy boundary fields and the inner-cache boundary field are taken from the captured word and held on their own outputs. Firmware-facing logic or a maintenance sequencer can use this block to turn the packed word into a stream of per-level records.

Top module: `cache_level_walker`

## Requirements
- R1: After reset the walker is idle. busy, lvl_valid, done, reserved_seen, level_count and every boundary output are zero.
- R2: When start is high while busy is low, the word is captured at that edge and busy is high from the next cycle. From that cycle the boundary outputs show these fields of the captured word: icb = bits [32:30], louu = bits [29:27], loc = bits [26:24] and louis = bits [23:21].
- R3: The cache kind of level n is word bits [3(n-1)+2 : 3(n-1)]. The codes are 000 none, 001 instruction, 010 data, 011 split, 100 unified, and 101 to 111 reserved. Level n (n from 1) is reported with lvl_valid high, lvl_num = n and lvl_ctype equal to that field, n cycles after the start edge.
- R4: The first level whose kind is 000 ends the walk. lvl_valid is not raised for it, and done pulses in its cycle with level_count = n-1. No field beyond it changes any output.
- R5: If all seven levels are non-empty, done pulses in the same cycle as the level-7 record and level_count = 7.
- R6: With tag_en high at the accepted start, lvl_ttype for level n is word bits [2(n-1)+34 : 2(n-1)+33]. The codes are 00 none, 01 separate tag cache, 10 unified in the same lines, and 11 unified in separate lines.
- R7: With tag_en low at the accepted start, lvl_ttype is 00 for every level, whatever the tag fields hold.
- R8: reserved_seen is set if a walked level has a kind from 101 to 111, or if any of word bits [63:47] is nonzero. Such a level is still counted and reported. Reserved kinds beyond the terminating level do not set it.
- R9: A start pulse while busy is high is ignored. The walk, its records and the boundary outputs continue from the original word.
- R10: level_count and reserved_seen are cleared by an accepted start, and they hold their final values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| id_word | input | 64 | Cache identification word |
| tag_en | input | 1 | Tag-cache feature present |
| busy | output | 1 | Walk in progress |
| lvl_valid | output | 1 | Per-level record strobe |
| lvl_num | output | 3 | Level number of the record |
| lvl_ctype | output | 3 | Cache kind of the record |
| lvl_ttype | output | 2 | Tag-cache kind of the record |
| done | output | 1 | One-cycle end-of-walk pulse |
| level_count | output | 3 | Number of present levels |
| reserved_seen | output | 1 | Reserved encoding observed |
| icb | output | 3 | Inner cache boundary field |
| louu | output | 3 | Unification level, uniprocessor |
| loc | output | 3 | Coherence level |
| louis | output | 3 | Unification level, inner shareable |

## Verification
A wrong level index appears at once on lvl_num or lvl_ctype, in the first record after the fault. A wrong termination decision appears as a missing or extra record and as done arriving in the wrong cycle, together with a wrong level_count. A corrupted capture register, or a start wrongly accepted mid-walk, shows on the boundary outputs in the next cycle. A tag-masking fault shows as a nonzero lvl_ttype on the first record of a walk started with the feature off.

// File: rtl/cwalk_pkg.sv
package cwalk_pkg;
  localparam int CT_W = 3;
  localparam int TT_W = 2;

  typedef enum logic [CT_W-1:0] {
    CK_NONE    = 3'b000,
    CK_INSTR   = 3'b001,
    CK_DATA    = 3'b010,
    CK_SPLIT   = 3'b011,
    CK_UNIFIED = 3'b100
  } cache_kind_e;

  typedef enum logic [TT_W-1:0] {
    TK_NONE     = 2'b00,
    TK_SEPARATE = 2'b01,
    TK_SAMELINE = 2'b10,
    TK_SPLITLN  = 2'b11
  } tag_kind_e;
endpackage

// File: rtl/cwalk_slice.sv
module cwalk_slice #(
  parameter int USED_W     = 47,
  parameter int MAX_LEVELS = 7,
  parameter int CT_LSB     = 0,
  parameter int TT_LSB     = 33,
  parameter int LVL_W      = 3
) (
  input  logic [USED_W-1:0]           word,
  input  logic [LVL_W-1:0]            idx,
  output logic [cwalk_pkg::CT_W-1:0]  ct,
  output logic [cwalk_pkg::TT_W-1:0]  tt
);
  import cwalk_pkg::*;

  logic [CT_W-1:0] ct_arr [MAX_LEVELS];
  logic [TT_W-1:0] tt_arr [MAX_LEVELS];

  for (genvar n = 0; n < MAX_LEVELS; n++) begin : g_lvl
    assign ct_arr[n] = word[CT_LSB + CT_W*n +: CT_W];
    assign tt_arr[n] = word[TT_LSB + TT_W*n +: TT_W];
  end

  always_comb begin
    ct = '0;
    tt = '0;
    for (int n = 0; n < MAX_LEVELS; n++) begin
      if (idx == LVL_W'(n + 1)) begin
        ct = ct_arr[n];
        tt = tt_arr[n];
      end
    end
  end
endmodule

// File: rtl/cwalk_class.sv
module cwalk_class (
  input  logic [cwalk_pkg::CT_W-1:0] ct,
  output logic                       empty,
  output logic                       rsvd
);
  import cwalk_pkg::*;

  assign empty = (ct == CK_NONE);
  assign rsvd  = (ct > CK_UNIFIED);
endmodule

// File: rtl/cache_level_walker.sv
module cache_level_walker #(
  parameter int WORD_W     = 64,
  parameter int MAX_LEVELS = 7,
  parameter int BND_W      = 3,
  parameter int CT_LSB     = 0,
  parameter int TT_LSB     = 33,
  parameter int LOUIS_LSB  = 21,
  parameter int LOC_LSB    = 24,
  parameter int LOUU_LSB   = 27,
  parameter int ICB_LSB    = 30,
  localparam int LVL_W     = $clog2(MAX_LEVELS + 1),
  localparam int CTW       = cwalk_pkg::CT_W,
  localparam int TTW       = cwalk_pkg::TT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] id_word,
  input  logic              tag_en,
  output logic              busy,
  output logic              lvl_valid,
  output logic [LVL_W-1:0]  lvl_num,
  output logic [CTW-1:0]    lvl_ctype,
  output logic [TTW-1:0]    lvl_ttype,
  output logic              done,
  output logic [LVL_W-1:0]  level_count,
  output logic              reserved_seen,
  output logic [BND_W-1:0]  icb,
  output logic [BND_W-1:0]  louu,
  output logic [BND_W-1:0]  loc,
  output logic [BND_W-1:0]  louis
);
  localparam int USED_W = TT_LSB + TTW * MAX_LEVELS;

  logic [USED_W-1:0] word_q;
  logic              tag_q;
  logic [LVL_W-1:0]  idx_q;
  logic [CTW-1:0]    ct_cur;
  logic [TTW-1:0]    tt_cur;
  logic              cur_empty, cur_rsvd;

  cwalk_slice #(
    .USED_W(USED_W), .MAX_LEVELS(MAX_LEVELS),
    .CT_LSB(CT_LSB), .TT_LSB(TT_LSB), .LVL_W(LVL_W)
  ) slice_i (
    .word(word_q), .idx(idx_q), .ct(ct_cur), .tt(tt_cur)
  );

  cwalk_class class_i (
    .ct(ct_cur), .empty(cur_empty), .rsvd(cur_rsvd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q        <= '0;
      tag_q         <= 1'b0;
      idx_q         <= '0;
      busy          <= 1'b0;
      lvl_valid     <= 1'b0;
      lvl_num       <= '0;
      lvl_ctype     <= '0;
      lvl_ttype     <= '0;
      done          <= 1'b0;
      level_count   <= '0;
      reserved_seen <= 1'b0;
    end else begin
      lvl_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          word_q        <= id_word[USED_W-1:0];
          tag_q         <= tag_en;
          idx_q         <= LVL_W'(1);
          busy          <= 1'b1;
          level_count   <= '0;
          reserved_seen <= |id_word[WORD_W-1:USED_W];
        end
      end else if (cur_empty) begin
        busy        <= 1'b0;
        done        <= 1'b1;
        level_count <= idx_q - LVL_W'(1);
      end else begin
        lvl_valid <= 1'b1;
        lvl_num   <= idx_q;
        lvl_ctype <= ct_cur;
        lvl_ttype <= tag_q ? tt_cur : '0;
        if (cur_rsvd) reserved_seen <= 1'b1;
        if (idx_q == LVL_W'(MAX_LEVELS)) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          level_count <= idx_q;
        end else begin
          idx_q <= idx_q + LVL_W'(1);
        end
      end
    end
  end

  assign icb   = word_q[ICB_LSB   +: BND_W];
  assign louu  = word_q[LOUU_LSB  +: BND_W];
  assign loc   = word_q[LOC_LSB   +: BND_W];
  assign louis = word_q[LOUIS_LSB +: BND_W];
endmodule

// File: rtl/cache_level_walker_chk.sv
module cache_level_walker_chk #(
  parameter int MAX_LEVELS = 7,
  parameter int BND_W      = 3,
  localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             tag_en,
  input logic             busy,
  input logic             lvl_valid,
  input logic [LVL_W-1:0] lvl_num,
  input logic [2:0]       lvl_ctype,
  input logic [1:0]       lvl_ttype,
  input logic             done,
  input logic [LVL_W-1:0] level_count,
  input logic [BND_W-1:0] icb,
  input logic [BND_W-1:0] louu,
  input logic [BND_W-1:0] loc,
  input logic [BND_W-1:0] louis
);
  logic tag_seen;
  always_ff @(posedge clk) begin
    if (rst) tag_seen <= 1'b0;
    else if (start && !busy) tag_seen <= tag_en;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) rst |=> !busy && !lvl_valid && !done); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    lvl_valid |-> (lvl_num >= LVL_W'(1)) && (lvl_num <= LVL_W'(MAX_LEVELS))); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    lvl_valid && $past(lvl_valid) |-> lvl_num == $past(lvl_num) + LVL_W'(1)); // R3
  AST_NO_EMPTY_RECORD: assert property (@(posedge clk) disable iff (rst)
    lvl_valid |-> lvl_ctype != 3'b000); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    level_count <= LVL_W'(MAX_LEVELS)); // R5
  AST_TAG_MASKED: assert property (@(posedge clk) disable iff (rst)
    lvl_valid && !tag_seen |-> lvl_ttype == 2'b00); // R7
  AST_BOUNDS_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(icb) && $stable(louu) && $stable(loc) && $stable(louis)); // R9
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(level_count)); // R10
endmodule

bind cache_level_walker cache_level_walker_chk #(.MAX_LEVELS(MAX_LEVELS), .BND_W(BND_W)) chk_i (.*);

// File: tb/cache_level_walker_tb.sv
`timescale 1ns/1ps
module cache_level_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst, start, tag_en;
  logic [63:0] id_word;
  logic        busy, lvl_valid, done, reserved_seen;
  logic [2:0]  lvl_num, lvl_ctype, level_count, icb, louu, loc, louis;
  logic [1:0]  lvl_ttype;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cache_level_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .id_word(id_word), .tag_en(tag_en),
    .busy(busy), .lvl_valid(lvl_valid), .lvl_num(lvl_num), .lvl_ctype(lvl_ctype),
    .lvl_ttype(lvl_ttype), .done(done), .level_count(level_count),
    .reserved_seen(reserved_seen), .icb(icb), .louu(louu), .loc(loc), .louis(louis)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] f_ct(input logic [63:0] w, input int n);
    return w[3*(n-1) +: 3];
  endfunction
  function automatic logic [1:0] f_tt(input logic [63:0] w, input int n);
    return w[33 + 2*(n-1) +: 2];
  endfunction
  function automatic int f_nlev(input logic [63:0] w);
    for (int n = 1; n <= 7; n++) if (f_ct(w, n) == 3'b000) return n - 1;
    return 7;
  endfunction
  function automatic logic f_rsvd(input logic [63:0] w);
    logic r = |w[63:47];
    for (int n = 1; n <= f_nlev(w); n++) if (f_ct(w, n) > 3'b100) r = 1'b1;
    return r;
  endfunction

  // Runs one walk; when intr is set, a start with word w2 is pulsed mid-walk (R9).
  task automatic walk(input logic [63:0] w, input logic te, input logic intr, input logic [63:0] w2);
    int nl = f_nlev(w);
    @(negedge clk);
    id_word = w; tag_en = te; start = 1'b1;
    @(negedge clk);
    start = 1'b0; id_word = ~w;
    chk("R2 busy", busy, 1);
    chk("R10 count cleared", level_count, 0);
    chk("R2 icb", icb, w[32:30]);
    chk("R2 louu", louu, w[29:27]);
    chk("R2 loc", loc, w[26:24]);
    chk("R2 louis", louis, w[23:21]);
    for (int k = 1; k <= 7; k++) begin
      if (intr && k == 1) begin id_word = w2; tag_en = ~te; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (k <= nl) begin
        chk("R3 valid", lvl_valid, 1);
        chk("R3 num", lvl_num, k);
        chk("R3 ctype", lvl_ctype, f_ct(w, k));
        if (te) chk("R6 ttype", lvl_ttype, f_tt(w, k));
        else    chk("R7 ttype masked", lvl_ttype, 0);
        chk("R5 done timing", done, k == 7);
      end else begin
        chk("R4 no record", lvl_valid, 0);
        chk("R4 done", done, 1);
      end
      if (intr) chk("R9 bounds kept", {icb, louu, loc, louis}, {w[32:30], w[29:27], w[26:24], w[23:21]});
      if (done) begin
        chk("R4 R5 count", level_count, nl);
        chk("R8 reserved", reserved_seen, f_rsvd(w));
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk("R10 idle hold", {busy, lvl_valid, done}, 0);
    chk("R10 count held", level_count, nl);
    chk("R10 reserved held", reserved_seen, f_rsvd(w));
  endtask

  function automatic logic [63:0] rnd_word();
    logic [63:0] w = {$urandom, $urandom};
    for (int n = 1; n <= 7; n++)
      w[3*(n-1) +: 3] = ($urandom_range(0, 9) == 0) ? 3'b000 : 3'($urandom_range(1, 7));
    if ($urandom_range(0, 3) != 0) w[63:47] = '0;
    return w;
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; tag_en = 1'b0; id_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {busy, lvl_valid, done, reserved_seen, level_count}, 0);
    chk("R1 reset bounds", {icb, louu, loc, louis}, 0);
    // all seven levels present, tags on
    walk({17'h0, 14'h2d1b, 3'b101, 3'b011, 3'b110, 3'b100, 21'o4321234}, 1'b1, 1'b0, '0);
    // level 1 empty, higher fields nonzero with reserved values: R4 R8
    walk({17'h0, 14'h3fff, 12'hfff, 9'h1ff, 21'o7777770}, 1'b1, 1'b0, '0);
    // level 3 empty, reserved beyond it ignored: R4 R8
    walk({17'h0, 14'h3fff, 12'h0, 9'h0, 21'o7770012}, 1'b0, 1'b0, '0);
    // reserved kind on a walked level, tags masked: R7 R8
    walk({17'h0, 14'h3fff, 12'h555, 9'h0, 21'o0004711}, 1'b0, 1'b0, '0);
    // nonzero reserved-zero high bits: R8
    walk({17'h1, 14'h0, 12'h0, 9'h0, 21'o0000134}, 1'b1, 1'b0, '0);
    // mid-walk start ignored: R9
    walk({17'h0, 14'h1234, 12'habc, 9'h0a5, 21'o1234123}, 1'b1, 1'b1, 64'hffff_ffff_ffff_ffff);
    for (int i = 0; i < 60; i++)
      walk(rnd_word(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rnd_word());
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule